// File: doc/BRIEF.md
# Guarded Idle Power-Mode Controller

This block sequences the low-power modes of a small 8-bit microcontroller. Software asks for a mode by writing a power-control register. A mode is entered only when an arm bit is written by one instruction and the matching go bit is written by the very next instruction. Any other completed instruction between the two cancels the request. There are two independent arm/go pairs, one for idle and one for power-down.

In idle the CPU clock enable drops and the peripheral clock enable stays high. Any interrupt that is both pending and enabled returns the block to running. Power-down drops both enables and ignores interrupts. Only the reset input ends it. The reset input is qualified by a counter and takes effect only after it has been high for two machine cycles of twelve oscillator clocks each.

The block also chooses the state of the address-latch strobe, the program-store strobe and the two multiplexed address/data ports. This choice depends on the mode and on whether the code fetch at entry was external. In running mode the core's own values pass through unchanged.

Top module: `pmode_ctrl`

## Requirements
- R1: The reset input must be high for 24 consecutive rising clock edges. The edge after that puts the block in running mode with `ctl_rd` = 0. A pulse of 23 edges changes nothing. A qualified reset also ends idle and power-down.
- R2: When `instr_done` is high and the mode is running, the write bus is evaluated. A write with bit 0 set arms idle. A write with bit 1 set at the next such boundary, while idle is armed, changes `mode` to 01 at that clock edge.
- R3: The arm flag is recomputed at every running-mode boundary, so any boundary without an arm write cancels it. A go write without a prior arm only clears the flag. A write carrying both arm and go bits only arms. A write without `instr_done` has no effect. Boundaries and writes outside running mode have no effect.
- R4: Power-down uses bit 2 as arm and bit 3 as go and enters `mode` 10 the same way. The go bit of one pair never completes the other pair. If both pairs complete at the same boundary, power-down wins.
- R5: The mode code is 00 running, 01 idle, 10 power-down, and 11 never appears. In running mode both `cpu_clk_en` and `periph_clk_en` are 1. In idle only `periph_clk_en` is 1. In power-down both are 0.
- R6: In idle, a nonzero `irq_pend & irq_en` returns `mode` to 00 at the next clock edge. A pending interrupt that is masked has no effect.
- R7: In power-down, interrupts are ignored and the mode holds until a qualified reset.
- R8: In idle, `ale` and `psen` are 1. In power-down, both are 0.
- R9: `code_ext` is latched at mode entry. In idle, an external fetch gives `p0_oe` = 0 and `p2_addr` = 1, and an internal fetch gives `p0_oe` = 1 and `p2_addr` = 0. In power-down, `p2_addr` = 0 and `p0_oe` is the inverse of the latched flag. Later changes of `code_ext` have no effect until the next entry.
- R10: `ctl_rd` bit 0 shows idle armed, bit 1 shows idle active, bit 2 shows power-down armed and bit 3 shows power-down active. The arm bits clear on entry. All four bits read 0 after a mode is exited.
- R11: In running mode, `ale`, `psen`, `p0_oe` and `p2_addr` follow `core_ale`, `core_psen`, `core_p0_oe` and `core_p2_addr`. `alt_live` is 1 in running mode and idle, and 0 in power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_in | input | 1 | Raw reset request, active high, qualified internally |
| instr_done | input | 1 | One-cycle pulse at each instruction boundary |
| wr_en | input | 1 | Power-control register write, valid with `instr_done` |
| wr_data | input | 4 | Write data: idle arm, idle go, down arm, down go |
| irq_pend | input | IRQ_N | Pending interrupt requests |
| irq_en | input | IRQ_N | Interrupt enable mask |
| code_ext | input | 1 | Current code fetch is external |
| core_ale | input | 1 | Core address-latch strobe |
| core_psen | input | 1 | Core program-store strobe |
| core_p0_oe | input | 1 | Core low port output enable |
| core_p2_addr | input | 1 | Core high port address select |
| cpu_clk_en | output | 1 | CPU clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| mode | output | 2 | Mode code |
| ctl_rd | output | 4 | Readback of the arm and active flags |
| ale | output | 1 | Address-latch strobe at the pin |
| psen | output | 1 | Program-store strobe at the pin |
| p0_oe | output | 1 | Low address/data port driven (0 = floating) |
| p2_addr | output | 1 | High port drives address (0 = data) |
| alt_live | output | 1 | Alternate functions keep driving (0 = hold last output) |

## Verification
Every mode change lands at the clock edge that samples its cause, whether that is the go write, the wake interrupt or the 25th edge of a qualified reset. The outputs decode the mode register combinationally, so a result appears one edge after its stimulus. The bench drives each stimulus 1 ns after an edge and clears it 1 ns after the next edge. It checks mode, readback and pins at that same point. Reset tests count exactly 23 and 24 high edges, then check one edge later, where the qualified reset has just taken effect or has been missed.

// File: rtl/pmode_pkg.sv
package pmode_pkg;

    typedef enum logic [1:0] {
        PM_RUN  = 2'b00,
        PM_IDLE = 2'b01,
        PM_DOWN = 2'b10
    } pm_mode_e;

    // number of arm/go pairs and their roles
    localparam int NPAIR     = 2;
    localparam int PAIR_IDLE = 0;
    localparam int PAIR_DOWN = 1;
    localparam int CTL_W     = 2 * NPAIR;

    // bit positions inside the control word; software depends on these
    function automatic int arm_pos(input int pair);
        return 2 * pair;
    endfunction

    function automatic int go_pos(input int pair);
        return 2 * pair + 1;
    endfunction

    typedef struct packed {
        pm_mode_e mode;
        logic     ext_q;
    } pm_state_t;

    typedef struct packed {
        logic ale;
        logic psen;
        logic p0_oe;
        logic p2_addr;
        logic alt_live;
    } pm_pins_t;

endpackage

// File: rtl/pmode_rstq.sv
module pmode_rstq #(
    parameter int MC_CLKS = 12,
    parameter int MC_HOLD = 2
) (
    input  logic clk,
    input  logic rst_in,
    output logic rst_int
);
    localparam int HOLD = MC_CLKS * MC_HOLD;
    localparam int CW   = $clog2(HOLD + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!rst_in) begin
            cnt_d = '0;
        end else if (cnt_q != CW'(HOLD)) begin
            cnt_d = cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        cnt_q <= cnt_d;
    end

    // high once the request has been seen on HOLD consecutive edges
    assign rst_int = (cnt_q == CW'(HOLD));

endmodule

// File: rtl/pmode_guard.sv
module pmode_guard (
    input  logic clk,
    input  logic clr,
    input  logic step,
    input  logic wr,
    input  logic arm_bit,
    input  logic go_bit,
    output logic armed,
    output logic fire
);
    logic armed_d, armed_q;

    always_comb begin
        armed_d = armed_q;
        if (clr) begin
            armed_d = 1'b0;
        end else if (step) begin
            // every completed instruction re-decides the flag
            armed_d = wr & arm_bit;
        end
    end

    always_ff @(posedge clk) begin
        armed_q <= armed_d;
    end

    assign armed = armed_q;
    assign fire  = step & wr & go_bit & armed_q;

endmodule

// File: rtl/pmode_pins.sv
module pmode_pins
    import pmode_pkg::*;
(
    input  pm_mode_e mode,
    input  logic     ext_q,
    input  logic     core_ale,
    input  logic     core_psen,
    input  logic     core_p0_oe,
    input  logic     core_p2_addr,
    output pm_pins_t pins
);
    always_comb begin
        pins = '{ale: core_ale, psen: core_psen, p0_oe: core_p0_oe,
                 p2_addr: core_p2_addr, alt_live: 1'b1};
        case (mode)
            PM_IDLE: begin
                pins.ale      = 1'b1;
                pins.psen     = 1'b1;
                pins.p0_oe    = ~ext_q;
                pins.p2_addr  = ext_q;
                pins.alt_live = 1'b1;
            end
            PM_DOWN: begin
                pins.ale      = 1'b0;
                pins.psen     = 1'b0;
                pins.p0_oe    = ~ext_q;
                pins.p2_addr  = 1'b0;
                pins.alt_live = 1'b0;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/pmode_ctrl.sv
module pmode_ctrl
    import pmode_pkg::*;
#(
    parameter int IRQ_N   = 4,
    parameter int MC_CLKS = 12,
    parameter int MC_HOLD = 2
) (
    input  logic             clk,
    input  logic             rst_in,
    input  logic             instr_done,
    input  logic             wr_en,
    input  logic [CTL_W-1:0] wr_data,
    input  logic [IRQ_N-1:0] irq_pend,
    input  logic [IRQ_N-1:0] irq_en,
    input  logic             code_ext,
    input  logic             core_ale,
    input  logic             core_psen,
    input  logic             core_p0_oe,
    input  logic             core_p2_addr,
    output logic             cpu_clk_en,
    output logic             periph_clk_en,
    output logic [1:0]       mode,
    output logic [CTL_W-1:0] ctl_rd,
    output logic             ale,
    output logic             psen,
    output logic             p0_oe,
    output logic             p2_addr,
    output logic             alt_live
);
    logic             rst_int;
    logic             step;
    logic             wake;
    logic             any_fire;
    logic [NPAIR-1:0] armed;
    logic [NPAIR-1:0] fire;
    pm_state_t        st_d, st_q;
    pm_pins_t         pins;

    pmode_rstq #(.MC_CLKS(MC_CLKS), .MC_HOLD(MC_HOLD)) u_rstq (
        .clk     (clk),
        .rst_in  (rst_in),
        .rst_int (rst_int)
    );

    assign step     = instr_done & (st_q.mode == PM_RUN);
    assign wake     = |(irq_pend & irq_en);
    assign any_fire = |fire;

    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        pmode_guard u_guard (
            .clk     (clk),
            .clr     (rst_int | any_fire),
            .step    (step),
            .wr      (wr_en),
            .arm_bit (wr_data[arm_pos(p)]),
            .go_bit  (wr_data[go_pos(p)]),
            .armed   (armed[p]),
            .fire    (fire[p])
        );
        assign ctl_rd[arm_pos(p)] = armed[p];
    end

    assign ctl_rd[go_pos(PAIR_IDLE)] = (st_q.mode == PM_IDLE);
    assign ctl_rd[go_pos(PAIR_DOWN)] = (st_q.mode == PM_DOWN);

    always_comb begin
        st_d = st_q;
        if (rst_int) begin
            st_d.mode  = PM_RUN;
            st_d.ext_q = 1'b0;
        end else begin
            case (st_q.mode)
                PM_RUN: begin
                    if (fire[PAIR_DOWN]) begin
                        st_d.mode  = PM_DOWN;
                        st_d.ext_q = code_ext;
                    end else if (fire[PAIR_IDLE]) begin
                        st_d.mode  = PM_IDLE;
                        st_d.ext_q = code_ext;
                    end
                end
                PM_IDLE: begin
                    if (wake) st_d.mode = PM_RUN;
                end
                PM_DOWN: ;
                default: st_d.mode = PM_RUN;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    pmode_pins u_pins (
        .mode         (st_q.mode),
        .ext_q        (st_q.ext_q),
        .core_ale     (core_ale),
        .core_psen    (core_psen),
        .core_p0_oe   (core_p0_oe),
        .core_p2_addr (core_p2_addr),
        .pins         (pins)
    );

    assign mode          = st_q.mode;
    assign cpu_clk_en    = (st_q.mode == PM_RUN);
    assign periph_clk_en = (st_q.mode != PM_DOWN);
    assign ale           = pins.ale;
    assign psen          = pins.psen;
    assign p0_oe         = pins.p0_oe;
    assign p2_addr       = pins.p2_addr;
    assign alt_live      = pins.alt_live;

endmodule

// File: rtl/pmode_chk.sv
module pmode_chk #(
    parameter int IRQ_N = 4
) (
    input logic             clk,
    input logic             rst_in,
    input logic             rst_int,
    input logic [1:0]       mode,
    input logic [3:0]       ctl_rd,
    input logic [IRQ_N-1:0] irq_pend,
    input logic [IRQ_N-1:0] irq_en,
    input logic             ale,
    input logic             psen
);
    AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (rst_in)
        mode != 2'b11);  // R5

    AST_IDLE_STROBES: assert property (@(posedge clk) disable iff (rst_in)
        (mode == 2'b01) |-> (ale && psen));  // R8

    AST_DOWN_STROBES: assert property (@(posedge clk) disable iff (rst_in)
        (mode == 2'b10) |-> (!ale && !psen));  // R8

    AST_IDLE_WAKE: assert property (@(posedge clk) disable iff (rst_in)
        (mode == 2'b01 && |(irq_pend & irq_en) && !rst_int) |=> (mode == 2'b00));  // R6

    AST_DOWN_HOLD: assert property (@(posedge clk) disable iff (rst_in)
        (mode == 2'b10 && !rst_int) |=> (mode == 2'b10));  // R7

    AST_ENTRY_ARMED: assert property (@(posedge clk) disable iff (rst_in)
        (mode != 2'b00 && $past(mode) == 2'b00) |-> $past(ctl_rd[0] | ctl_rd[2]));  // R2

    AST_EXIT_CLEARS: assert property (@(posedge clk) disable iff (rst_in)
        (mode == 2'b00 && $past(mode) != 2'b00) |-> (ctl_rd == 4'b0000));  // R10

endmodule

bind pmode_ctrl pmode_chk #(.IRQ_N(IRQ_N)) u_chk (
    .clk      (clk),
    .rst_in   (rst_in),
    .rst_int  (rst_int),
    .mode     (mode),
    .ctl_rd   (ctl_rd),
    .irq_pend (irq_pend),
    .irq_en   (irq_en),
    .ale      (ale),
    .psen     (psen)
);

// File: tb/pmode_ctrl_test.sv
`timescale 1ns/1ps
module pmode_ctrl_test;

    localparam int IRQ_N = 4;

    logic             clk = 1'b0;
    logic             rst_in = 1'b1;
    logic             instr_done = 1'b0;
    logic             wr_en = 1'b0;
    logic [3:0]       wr_data = '0;
    logic [IRQ_N-1:0] irq_pend = '0;
    logic [IRQ_N-1:0] irq_en = '0;
    logic             code_ext = 1'b1;
    logic             core_ale = 1'b0;
    logic             core_psen = 1'b0;
    logic             core_p0_oe = 1'b0;
    logic             core_p2_addr = 1'b0;
    logic             cpu_clk_en, periph_clk_en, ale, psen, p0_oe, p2_addr, alt_live;
    logic [1:0]       mode;
    logic [3:0]       ctl_rd;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    pmode_ctrl #(.IRQ_N(IRQ_N)) uut (
        .clk(clk), .rst_in(rst_in), .instr_done(instr_done), .wr_en(wr_en),
        .wr_data(wr_data), .irq_pend(irq_pend), .irq_en(irq_en), .code_ext(code_ext),
        .core_ale(core_ale), .core_psen(core_psen), .core_p0_oe(core_p0_oe),
        .core_p2_addr(core_p2_addr), .cpu_clk_en(cpu_clk_en),
        .periph_clk_en(periph_clk_en), .mode(mode), .ctl_rd(ctl_rd), .ale(ale),
        .psen(psen), .p0_oe(p0_oe), .p2_addr(p2_addr), .alt_live(alt_live)
    );

    typedef struct packed {
        logic       instr;
        logic       wr;
        logic [3:0] data;
        logic [3:0] pend;
        logic [3:0] en;
        logic [1:0] exp_mode;
        logic [3:0] exp_rd;
        logic [3:0] req;
    } vec_t;

    localparam int NVEC = 20;
    localparam vec_t VEC [NVEC] = '{
        '{1'b1, 1'b1, 4'b0001, 4'h0, 4'h0, 2'b00, 4'b0001, 4'd2},  // R2 arm idle
        '{1'b1, 1'b1, 4'b0010, 4'h0, 4'h0, 2'b01, 4'b0010, 4'd2},  // R2 go idle
        '{1'b1, 1'b1, 4'b0001, 4'h0, 4'h0, 2'b01, 4'b0010, 4'd3},  // R3 boundary in idle ignored
        '{1'b0, 1'b0, 4'b0000, 4'h1, 4'h0, 2'b01, 4'b0010, 4'd6},  // R6 masked irq
        '{1'b0, 1'b0, 4'b0000, 4'h4, 4'h4, 2'b00, 4'b0000, 4'd6},  // R6 wake
        '{1'b1, 1'b1, 4'b0001, 4'h0, 4'h0, 2'b00, 4'b0001, 4'd3},  // R3 arm
        '{1'b1, 1'b0, 4'b0000, 4'h0, 4'h0, 2'b00, 4'b0000, 4'd3},  // R3 other instr cancels
        '{1'b1, 1'b1, 4'b0010, 4'h0, 4'h0, 2'b00, 4'b0000, 4'd3},  // R3 go without arm
        '{1'b0, 1'b1, 4'b0001, 4'h0, 4'h0, 2'b00, 4'b0000, 4'd3},  // R3 write off boundary
        '{1'b1, 1'b1, 4'b0011, 4'h0, 4'h0, 2'b00, 4'b0001, 4'd3},  // R3 arm+go only arms
        '{1'b1, 1'b1, 4'b0011, 4'h0, 4'h0, 2'b01, 4'b0010, 4'd10}, // R10 arm cleared on entry
        '{1'b0, 1'b0, 4'b0000, 4'h8, 4'h8, 2'b00, 4'b0000, 4'd10}, // R10 zero after exit
        '{1'b1, 1'b1, 4'b0100, 4'h0, 4'h0, 2'b00, 4'b0100, 4'd4},  // R4 arm down
        '{1'b1, 1'b1, 4'b0010, 4'h0, 4'h0, 2'b00, 4'b0000, 4'd4},  // R4 idle go no match
        '{1'b1, 1'b1, 4'b0001, 4'h0, 4'h0, 2'b00, 4'b0001, 4'd4},  // R4 arm idle
        '{1'b1, 1'b1, 4'b1000, 4'h0, 4'h0, 2'b00, 4'b0000, 4'd4},  // R4 down go no match
        '{1'b1, 1'b1, 4'b0101, 4'h0, 4'h0, 2'b00, 4'b0101, 4'd4},  // R4 arm both
        '{1'b1, 1'b1, 4'b1010, 4'h0, 4'h0, 2'b10, 4'b1000, 4'd4},  // R4 both fire, down wins
        '{1'b0, 1'b0, 4'b0000, 4'hF, 4'hF, 2'b10, 4'b1000, 4'd7},  // R7 irq ignored
        '{1'b1, 1'b1, 4'b0001, 4'h0, 4'h0, 2'b10, 4'b1000, 4'd7}   // R7 boundary ignored
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // {cpu, periph, ale, psen, p0_oe, p2_addr, alt_live}
    function automatic logic [7:0] pin_vec();
        return {1'b0, cpu_clk_en, periph_clk_en, ale, psen, p0_oe, p2_addr, alt_live};
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic instr(input logic wr, input logic [3:0] d);
        instr_done = 1'b1;
        wr_en = wr;
        wr_data = d;
        tick();
        instr_done = 1'b0;
        wr_en = 1'b0;
        wr_data = '0;
    endtask

    task automatic pulse_reset(input int edges);
        rst_in = 1'b1;
        repeat (edges) @(posedge clk);
        #1;
        rst_in = 1'b0;
        tick();
    endtask

    initial begin
        repeat (30) @(posedge clk);
        #1;
        rst_in = 1'b0;
        tick();
        check("R1 reset mode", {6'd0, mode}, 8'd0);
        check("R1 reset readback", {4'd0, ctl_rd}, 8'd0);

        // table walk
        for (int i = 0; i < NVEC; i++) begin
            instr_done = VEC[i].instr;
            wr_en = VEC[i].wr;
            wr_data = VEC[i].data;
            irq_pend = VEC[i].pend;
            irq_en = VEC[i].en;
            tick();
            instr_done = 1'b0;
            wr_en = 1'b0;
            wr_data = '0;
            irq_pend = '0;
            irq_en = '0;
            check($sformatf("R%0d vec%0d", VEC[i].req, i),
                  {2'd0, mode, ctl_rd}, {2'd0, VEC[i].exp_mode, VEC[i].exp_rd});
        end

        // power-down, external fetch latched
        check("R8 R9 R5 down ext pins", pin_vec(), 8'b0000_0000);
        code_ext = 1'b0;
        tick();
        check("R9 latched fetch source", pin_vec(), 8'b0000_0000);

        pulse_reset(23);
        check("R1 23-edge pulse ignored", {6'd0, mode}, 8'b10);
        pulse_reset(24);
        check("R1 R7 24-edge reset exits down", {2'd0, mode, ctl_rd}, 8'd0);

        // running passthrough
        core_ale = 1'b1; core_psen = 1'b0; core_p0_oe = 1'b1; core_p2_addr = 1'b0;
        #1;
        check("R11 R5 run passthrough a", pin_vec(), 8'b0111_0101);
        core_ale = 1'b0; core_psen = 1'b1; core_p0_oe = 1'b0; core_p2_addr = 1'b1;
        #1;
        check("R11 R5 run passthrough b", pin_vec(), 8'b0110_1011);

        // idle with internal fetch
        code_ext = 1'b0;
        instr(1'b1, 4'b0001);
        instr(1'b1, 4'b0010);
        check("R8 R9 R5 idle int pins", pin_vec(), 8'b0011_1101);
        code_ext = 1'b1;
        tick();
        check("R9 idle source held", pin_vec(), 8'b0011_1101);
        irq_pend = 4'b0010; irq_en = 4'b0010;
        tick();
        irq_pend = '0; irq_en = '0;
        check("R6 wake", {6'd0, mode}, 8'd0);

        // idle with external fetch, then reset exits idle
        instr(1'b1, 4'b0001);
        instr(1'b1, 4'b0010);
        check("R9 idle ext pins", pin_vec(), 8'b0011_1011);
        pulse_reset(24);
        check("R1 reset exits idle", {2'd0, mode, ctl_rd}, 8'd0);

        // power-down with internal fetch
        code_ext = 1'b0;
        instr(1'b1, 4'b0100);
        instr(1'b1, 4'b1000);
        check("R9 R8 down int pins", pin_vec(), 8'b0000_0100);
        check("R10 down readback", {4'd0, ctl_rd}, 8'b0000_1000);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule